// File: doc/BRIEF.md
# General-Purpose Pin Bank with Event Steering

This block holds the control state for a bank of general-purpose pins. Software programs each pin through a single configuration word. The word selects whether the pin is handed to its native function or kept as a general-purpose pin. It also selects input or output, the level to drive, a blinking output, input inversion, and how the pin's input event is steered to one of two system interrupt lines. One is a system-management interrupt (`smi`) and the other a system-control interrupt (`sci`).

Input pins pass through a two-flop synchronizer. A pin's sticky status bit is set whenever its synchronized input sits at the active level, where inversion decides which level is active. Software clears the status by writing ones to the status word. Each pin has a 2-bit steering code and one enable per destination, and these decide whether a pending status drives `smi`, `sci` or neither. The pad drivers and the native functions sit outside the block. They use `gpio_sel`, `pin_oe` and `pin_out` to build the real pad.

Top module: `gpio_event_bank`

## Requirements
- R1: After reset every pin is native (`gpio_sel`=0), `pin_oe` is 0, all status bits are 0, and `smi` and `sci` are 0.
- R2: Configuration word bit 8 selects the pin's owner: 0 hands the pin to its native function (`gpio_sel`=0, `pin_oe`=0), and 1 makes it a general-purpose pin (`gpio_sel`=1).
- R3: Configuration word bit 9 sets the direction of a general-purpose pin. With 0 the pin is an output: `pin_oe`=1 and `pin_out` follows bit 10 (the level). With 1 the pin is an input and `pin_oe`=0.
- R4: The configuration word for pin i is at address i. On reads, bits 7:0 return i, and writes to those bits are ignored. Bit 10 reads the written level for an output and the synchronized input value for an input.
- R5: Bit 12 is the invert bit. With invert at 0, an input pin's status is set while its synchronized input is high. With invert at 1, it is set while the input is low. A change on `pin_in` can first show in status after the third rising clock edge.
- R6: The status word at address NPINS reads each pin's status at bit i. Writing 1 to bit i clears that bit and writing 0 leaves it. If the set condition holds in the same cycle as a clear, the set wins.
- R7: Bits 14:13 hold the steering code. Bit 15 is the SMI enable and bit 16 is the SCI enable. Code 01 drives `smi` when the SMI enable is 1. Code 10 drives `sci` when the SCI enable is 1. Codes 00 and 11 drive neither.
- R8: A pin that is native or an output never sets status, and never drives `smi` or `sci`, even when its status was set earlier.
- R9: When bit 11 (blink) is 1 on an output, `pin_out` toggles every BLINK_DIV clock cycles instead of following the level. When bit 11 is 0, `pin_out` holds steady between writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address: pin words, then the status word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | NPINS | Raw pin input levels |
| pin_out | output | NPINS | Value to drive on output pins |
| pin_oe | output | NPINS | Output enable per pin |
| gpio_sel | output | NPINS | 1 = general-purpose pin, 0 = native function |
| smi | output | 1 | System-management interrupt request |
| sci | output | 1 | System-control interrupt request |

## Verification
Four properties are checked on every cycle. Status bits stay set unless a status write occurs. No status bit rises on a pin that was not a general-purpose input. Each interrupt line is backed by a pending status bit of a qualified, enabled pin. A non-blinking output stays steady between writes. Other behaviour can only be shown by the bench scenarios. These include the three-edge synchronizer latency, the invert polarity, the set-wins-over-clear rule, the full steering-code table, the read-only pin number field, and the blink period.

// File: rtl/gpio_event_bank.sv
module gpio_event_bank #(
  parameter int NPINS     = 8,
  parameter int ADDR_W    = 4,
  parameter int BLINK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  gpio_sel,
  output logic              smi,
  output logic              sci
);
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(NPINS);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BLINK_DIV - 1);

  logic [NPINS-1:0] use_r, dir_r, lvl_r, blk_r, inv_r, smien_r, scien_r;
  logic [NPINS-1:0][1:0] route_r;
  logic [NPINS-1:0] sync1, sync2, status, qual, set_v, clr_v, smi_hit, sci_hit;
  logic [NPINS-1:0][31:0] cfg_rd;
  logic [CNT_W-1:0] bcnt;
  logic bphase;
  logic sts_wr;

  assign sts_wr = wr_en && (addr == STS_A);
  assign qual   = use_r & dir_r;
  assign set_v  = qual & (sync2 ^ inv_r);
  assign clr_v  = sts_wr ? wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_r   <= '0;
      dir_r   <= '0;
      lvl_r   <= '0;
      blk_r   <= '0;
      inv_r   <= '0;
      smien_r <= '0;
      scien_r <= '0;
      route_r <= '0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (wr_en && addr == ADDR_W'(i)) begin
          use_r[i]   <= wdata[8];
          dir_r[i]   <= wdata[9];
          lvl_r[i]   <= wdata[10];
          blk_r[i]   <= wdata[11];
          inv_r[i]   <= wdata[12];
          route_r[i] <= wdata[14:13];
          smien_r[i] <= wdata[15];
          scien_r[i] <= wdata[16];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      status <= '0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      status <= (status & ~clr_v) | set_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt   <= '0;
      bphase <= 1'b0;
    end else if (bcnt == CNT_LAST) begin
      bcnt   <= '0;
      bphase <= ~bphase;
    end else begin
      bcnt <= bcnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign smi_hit[g] = status[g] & qual[g] & smien_r[g] & (route_r[g] == 2'b01);
    assign sci_hit[g] = status[g] & qual[g] & scien_r[g] & (route_r[g] == 2'b10);
    assign pin_out[g] = blk_r[g] ? bphase : lvl_r[g];
    assign cfg_rd[g]  = {15'd0, scien_r[g], smien_r[g], route_r[g], inv_r[g], blk_r[g],
                         (dir_r[g] ? sync2[g] : lvl_r[g]), dir_r[g], use_r[g], 8'(g)};
  end

  assign pin_oe   = use_r & ~dir_r;
  assign gpio_sel = use_r;
  assign smi      = |smi_hit;
  assign sci      = |sci_hit;

  always_comb begin
    rdata = '0;
    if (addr < STS_A)      rdata = cfg_rd[addr[IDX_W-1:0]];
    else if (addr == STS_A) rdata[NPINS-1:0] = status;
  end

  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sts_wr) |-> (($past(status) & ~status) == '0));

  a_r8_no_rise_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(use_r & dir_r)) == '0));

  a_r7_smi_backed: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> ((status & smien_r & use_r & dir_r) != '0));

  a_r7_sci_backed: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> ((status & scien_r & use_r & dir_r) != '0));

  a_r9_steady_level: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (((pin_out ^ $past(pin_out)) & ~blk_r) == '0));
endmodule

// File: tb/gpio_event_bank_test.sv
module gpio_event_bank_test;
  localparam int NP = 8;
  localparam int AW = 4;
  localparam int BD = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe, gpio_sel;
  logic smi, sci;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_event_bank #(.NPINS(NP), .ADDR_W(AW), .BLINK_DIV(BD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .gpio_sel(gpio_sel),
    .smi(smi), .sci(sci));

  function automatic logic [31:0] cfg(bit u, bit d, bit l, bit b, bit inv,
                                      logic [1:0] rt, bit se, bit ce);
    return {15'd0, ce, se, rt, inv, b, l, d, u, 8'hA5};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 smi", 32'(smi), 0);
    check("R1 sci", 32'(sci), 0);
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 gpio_sel", 32'(gpio_sel), 0);
    rd(AW'(NP), d); check("R1 status", d, 0);
    rd(3, d); check("R4 pin number after reset", d, 32'h3);
  endtask

  task automatic t_output;
    logic [31:0] d;
    wr(0, cfg(1, 0, 1, 0, 0, 0, 0, 0));
    check("R2 gpio_sel pin0", 32'(gpio_sel[0]), 1);
    check("R3 oe pin0", 32'(pin_oe[0]), 1);
    check("R3 drive high", 32'(pin_out[0]), 1);
    rd(0, d);
    check("R4 number read-only", 32'(d[7:0]), 0);
    check("R4 level readback", 32'(d[10]), 1);
    wr(0, cfg(1, 0, 0, 0, 0, 0, 0, 0));
    check("R3 drive low", 32'(pin_out[0]), 0);
  endtask

  task automatic t_native;
    logic [31:0] d;
    wr(1, cfg(0, 1, 0, 0, 0, 2'b01, 1, 1));
    pin_in[1] = 1'b1;
    idle(5);
    check("R2 native sel", 32'(gpio_sel[1]), 0);
    check("R2 native oe", 32'(pin_oe[1]), 0);
    rd(AW'(NP), d); check("R8 native no status", 32'(d[1]), 0);
    check("R8 native no smi", 32'(smi), 0);
    pin_in[1] = 1'b0;
  endtask

  task automatic t_input;
    logic [31:0] d;
    wr(2, cfg(1, 1, 0, 0, 0, 0, 0, 0));
    check("R3 input oe", 32'(pin_oe[2]), 0);
    idle(3);
    rd(AW'(NP), d); check("R5 idle low", 32'(d[2]), 0);
    pin_in[2] = 1'b1;
    idle(2);
    rd(AW'(NP), d); check("R5 not before 3rd edge", 32'(d[2]), 0);
    idle(1);
    rd(AW'(NP), d); check("R5 set after 3rd edge", 32'(d[2]), 1);
    rd(2, d); check("R4 input readback", 32'(d[10]), 1);
    pin_in[2] = 1'b0;
    idle(3);
    wr(AW'(NP), 32'h0);
    rd(AW'(NP), d); check("R6 write zero keeps", 32'(d[2]), 1);
    wr(AW'(NP), 32'h4);
    rd(AW'(NP), d); check("R6 w1c clears", 32'(d[2]), 0);
    wr(2, cfg(1, 1, 0, 0, 1, 0, 0, 0));
    idle(1);
    rd(AW'(NP), d); check("R5 invert sets on low", 32'(d[2]), 1);
    wr(AW'(NP), 32'h4);
    rd(AW'(NP), d); check("R6 set wins over clear", 32'(d[2]), 1);
    pin_in[2] = 1'b1;
    idle(3);
    wr(AW'(NP), 32'h4);
    rd(AW'(NP), d); check("R5 invert high stays clear", 32'(d[2]), 0);
  endtask

  task automatic t_route;
    logic [31:0] d;
    pin_in[3] = 1'b1;
    wr(3, cfg(1, 1, 0, 0, 0, 2'b00, 1, 1));
    idle(4);
    rd(AW'(NP), d); check("R7 status pending", 32'(d[3]), 1);
    check("R7 code00 smi", 32'(smi), 0);
    check("R7 code00 sci", 32'(sci), 0);
    wr(3, cfg(1, 1, 0, 0, 0, 2'b01, 1, 1));
    check("R7 code01 smi", 32'(smi), 1);
    check("R7 code01 sci", 32'(sci), 0);
    wr(3, cfg(1, 1, 0, 0, 0, 2'b01, 0, 1));
    check("R7 code01 smi disabled", 32'(smi), 0);
    wr(3, cfg(1, 1, 0, 0, 0, 2'b10, 1, 1));
    check("R7 code10 sci", 32'(sci), 1);
    check("R7 code10 smi", 32'(smi), 0);
    wr(3, cfg(1, 1, 0, 0, 0, 2'b10, 1, 0));
    check("R7 code10 sci disabled", 32'(sci), 0);
    wr(3, cfg(1, 1, 0, 0, 0, 2'b11, 1, 1));
    check("R7 code11 smi", 32'(smi), 0);
    check("R7 code11 sci", 32'(sci), 0);
    wr(3, cfg(1, 0, 0, 0, 0, 2'b10, 1, 1));
    check("R8 output masks old status", 32'(sci), 0);
    pin_in[3] = 1'b0;
    wr(AW'(NP), 32'h8);
  endtask

  task automatic t_output_quiet;
    logic [31:0] d;
    wr(4, cfg(1, 0, 0, 0, 1, 2'b01, 1, 0));
    idle(5);
    rd(AW'(NP), d); check("R8 output no status", 32'(d[4]), 0);
    check("R8 output no smi", 32'(smi), 0);
  endtask

  task automatic t_blink;
    int changes = 0;
    logic prev;
    wr(5, cfg(1, 0, 0, 1, 0, 0, 0, 0));
    prev = pin_out[5];
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (pin_out[5] !== prev) changes++;
      prev = pin_out[5];
    end
    n_chk++;
    if (changes < 3 || changes > 4) begin
      n_bad++;
      $display("FAIL R9 blink toggles actual=%0d expected=3..4", changes);
    end
    wr(5, cfg(1, 0, 1, 0, 0, 0, 0, 0));
    changes = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (pin_out[5] !== 1'b1) changes++;
    end
    check("R9 steady after blink off", 32'(changes), 0);
  endtask

  initial begin
    #40000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_output;
    t_native;
    t_input;
    t_route;
    t_output_quiet;
    t_blink;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule